// File: doc/BRIEF.md
# Tapped Segmented Delay Pipe

The block delays a wide word by a fixed number of enabled clock cycles. Every bit lane carries the same delay. Each lane is a chain of short shift segments. Each segment can be addressed to any length up to its capacity, and a single register sits at the head of every segment. The segment lengths are chosen so that the boundary registers and the segments together add up to exactly the full depth. With the default settings the depth is 64 stages, built from four boundary registers and four segments of 15 stages each.

Besides the delayed word, the block gives two tap words. The first-column tap shows every lane one stage deep. The diagonal tap reads each lane at its own stage in the first half of the pipe: lane i is read at stage (i mod 32) + 1, so the position wraps after 32 lanes. Inside a segment only the addressed output can be seen. A diagonal point that falls inside a segment is therefore reached through a short branch segment, fed from that segment's boundary register and addressed to the required offset. A clock enable gates all shifting. The reset is asynchronous and active-low, and its release passes through a two-flop synchronizer.

Top module: `tapped_delay_pipe`

## Requirements
- R1: `dout[i]` equals the value that `din[i]` had at the enabled edge 64 enabled edges earlier. Until 64 enabled edges have occurred since reset, `dout` is zero.
- R2: After each enabled edge, `tap_first` equals the `din` sampled at that edge.
- R3: For lanes 0 to 31, `tap_diag[i]` equals the `din[i]` sampled (i mod 32) + 1 enabled edges earlier. For example, lane 0 is one edge deep and lane 31 is 32 edges deep.
- R4: While `en` is low, no stage shifts. `dout`, `tap_first` and `tap_diag` keep their values, and disabled edges do not count toward any delay.
- R5: While `rst_n` is low, every stage is cleared, so all outputs read zero at once. Shifting starts only after two rising edges with `rst_n` high.
- R6: Lanes behave independently, and the diagonal depth wraps. Lane 32 reads at stage 1 and lane 39 reads at stage 8, each holding only its own lane's history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Shift enable |
| din | input | LANES | Input word, one bit per lane |
| dout | output | LANES | Word delayed by the full depth |
| tap_first | output | LANES | Stage 1 of every lane |
| tap_diag | output | LANES | Lane i read at stage (i mod 32) + 1 |

## Verification
An error in a boundary register corrupts `tap_first` on the next enabled edge. It also reaches `dout` after the remaining depth, so a fault in the front stage appears at the output 63 enabled edges later. A wrong segment length or address moves the diagonal tap of the affected lanes by one or more edges, and it shifts the whole-word delay on `dout` as well. Both show up within one pass of a fresh value through the pipe. Comparing every tap on every cycle against a full per-lane history catches an off-by-one delay, a shift during a disabled edge, or crosstalk between lanes in the first cycle where the pattern tells the two cases apart.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  // Stage (1-based) at which a lane is read by the diagonal tap.
  function automatic int diag_stage(input int lane, input int span);
    return (lane % span) + 1;
  endfunction
endpackage

// File: rtl/tdp_rst_sync.sv
module tdp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [1:0] sync_q, sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ni = sync_q[1];
endmodule

// File: rtl/tdp_stage.sv
module tdp_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d,
  output logic q
);
  logic q_d;

  always_comb q_d = en ? d : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end
endmodule

// File: rtl/tdp_seg.sv
module tdp_seg #(
  parameter int CAP = 15,
  parameter int AW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          d,
  input  logic [AW-1:0] addr,   // length minus one
  output logic          q
);
  logic [CAP-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (en) begin
      sr_d[0] = d;
      for (int k = 1; k < CAP; k++) sr_d[k] = sr_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  always_comb begin
    q = 1'b0;
    for (int k = 0; k < CAP; k++)
      if (addr == AW'(k)) q = sr_q[k];
  end

  // Length-one setting: output follows the input one enabled edge later (R3).
  p_len1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && addr == '0) |=> (addr != '0) || (q == $past(d)));
endmodule

// File: rtl/tdp_lane.sv
module tdp_lane #(
  parameter int NSEG      = 4,
  parameter int SEG_DEPTH = 16,
  parameter int DIAG      = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic dout,
  output logic tap_first,
  output logic tap_diag
);
  localparam int SEGLEN = SEG_DEPTH - 1;
  localparam int AW     = $clog2(SEG_DEPTH);
  localparam int DSEG   = (DIAG - 1) / SEG_DEPTH;
  localparam int DOFF   = (DIAG - 1) % SEG_DEPTH;

  logic [NSEG-1:0] bnd_q;
  logic [NSEG-1:0] seg_q;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic bnd_in;
    if (s == 0) begin : g_head
      assign bnd_in = din;
    end else begin : g_link
      assign bnd_in = seg_q[s-1];
    end
    tdp_stage u_bnd (
      .clk(clk), .rst_n(rst_n), .en(en), .d(bnd_in), .q(bnd_q[s])
    );
    tdp_seg #(.CAP(SEGLEN), .AW(AW)) u_seg (
      .clk(clk), .rst_n(rst_n), .en(en), .d(bnd_q[s]),
      .addr(AW'(SEGLEN - 1)), .q(seg_q[s])
    );
  end

  assign dout      = seg_q[NSEG-1];
  assign tap_first = bnd_q[0];

  if (DOFF == 0) begin : g_diag_bnd
    assign tap_diag = bnd_q[DSEG];
  end else begin : g_diag_branch
    tdp_seg #(.CAP(DOFF), .AW(AW)) u_branch (
      .clk(clk), .rst_n(rst_n), .en(en), .d(bnd_q[DSEG]),
      .addr(AW'(DOFF - 1)), .q(tap_diag)
    );
  end

  // First column sees the lane input one enabled edge later (R2).
  p_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> tap_first == $past(din));

  if (DIAG == 2) begin : g_chk_diag2
    // Second-stage diagonal trails the first column by one enabled edge (R3).
    p_diag2_r3: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> tap_diag == $past(tap_first));
  end
endmodule

// File: rtl/tapped_delay_pipe.sv
module tapped_delay_pipe #(
  parameter int LANES     = 40,
  parameter int SEG_DEPTH = 16,
  parameter int NSEG      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] dout,
  output logic [LANES-1:0] tap_first,
  output logic [LANES-1:0] tap_diag
);
  localparam int DEPTH     = SEG_DEPTH * NSEG;
  localparam int DIAG_SPAN = DEPTH / 2;

  logic rst_ni;

  tdp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ni(rst_ni));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int STG = tdp_pkg::diag_stage(i, DIAG_SPAN);
    tdp_lane #(.NSEG(NSEG), .SEG_DEPTH(SEG_DEPTH), .DIAG(STG)) u_lane (
      .clk(clk), .rst_n(rst_ni), .en(en), .din(din[i]),
      .dout(dout[i]), .tap_first(tap_first[i]), .tap_diag(tap_diag[i])
    );
  end

  // Disabled edges change nothing visible (R4).
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    !en |=> $stable(dout) && $stable(tap_first) && $stable(tap_diag));
endmodule

// File: tb/tapped_delay_pipe_test.sv
module tapped_delay_pipe_test;
  localparam int LANES = 40;
  localparam int DEPTH = 64;
  localparam int SPAN  = 32;

  logic clk = 1'b0;
  logic rst_n, en;
  logic [LANES-1:0] din, dout, tap_first, tap_diag;
  logic [LANES-1:0] hist [0:DEPTH];
  logic [LANES-1:0] prev_out, prev_first, prev_diag;
  logic prev_hold;
  int runs = 0;
  int fails = 0;

  // en bit, 8-bit seed
  localparam logic [8:0] TBL [12] = '{
    9'h1A5, 9'h1FF, 9'h000, 9'h13C, 9'h100, 9'h15A,
    9'h0C3, 9'h1E1, 9'h181, 9'h07E, 9'h10F, 9'h1F0
  };

  always #5 clk = ~clk;

  tapped_delay_pipe uut (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din),
    .dout(dout), .tap_first(tap_first), .tap_diag(tap_diag)
  );

  task automatic check(input string req, input logic [LANES-1:0] act,
                       input logic [LANES-1:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [LANES-1:0] exp_diag();
    logic [LANES-1:0] r;
    for (int l = 0; l < LANES; l++) r[l] = hist[(l % SPAN) + 1][l];
    return r;
  endfunction

  task automatic clear_model();
    for (int k = 0; k <= DEPTH; k++) hist[k] = '0;
  endtask

  task automatic check_all();
    logic [LANES-1:0] d;
    d = exp_diag();
    check("R1 dout", dout, hist[DEPTH]);
    check("R2 tap_first", tap_first, hist[1]);
    check("R3 tap_diag low lanes", LANES'(tap_diag[SPAN-1:0]), LANES'(d[SPAN-1:0]));
    check("R6 tap_diag wrapped lanes", LANES'(tap_diag[LANES-1:SPAN]), LANES'(d[LANES-1:SPAN]));
    if (prev_hold) begin
      check("R4 dout hold", dout, prev_out);
      check("R4 first hold", tap_first, prev_first);
      check("R4 diag hold", tap_diag, prev_diag);
    end
  endtask

  // Called just after a falling edge.
  task automatic step(input logic en_v, input logic [LANES-1:0] din_v);
    check_all();
    prev_out = dout; prev_first = tap_first; prev_diag = tap_diag;
    en = en_v; din = din_v;
    @(posedge clk);
    #1;
    if (en_v) begin
      for (int k = DEPTH; k >= 2; k--) hist[k] = hist[k-1];
      hist[1] = din_v;
    end
    prev_hold = !en_v;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; din = '0; prev_hold = 1'b0;
    prev_out = '0; prev_first = '0; prev_diag = '0;
    clear_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R5 reset dout", dout, '0);
    check("R5 reset first", tap_first, '0);
    check("R5 reset diag", tap_diag, '0);
    rst_n = 1'b1;
    for (int c = 0; c < 3; c++) step(1'b0, '1);

    // Table-driven run: mixed enable and data patterns.
    for (int c = 0; c < 300; c++) begin
      logic [8:0] e;
      e = TBL[c % 12];
      step(e[8], {5{e[7:0]}} ^ LANES'(c * 32'h9E3779B1));
    end

    // Mid-run reset clears everything at once (R5).
    rst_n = 1'b0;
    #1;
    check("R5 midrun dout", dout, '0);
    check("R5 midrun first", tap_first, '0);
    check("R5 midrun diag", tap_diag, '0);
    clear_model();
    prev_hold = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 3; c++) step(1'b0, '1);

    // Single all-ones word walking through zeros: every diagonal depth hit.
    step(1'b1, '1);
    for (int c = 0; c < 70; c++) step(1'b1, '0);
    // Walking lane-distinct pattern with idle gaps.
    for (int c = 0; c < 80; c++) step((c % 5) != 3, LANES'(40'h1 << (c % LANES)) ^ 40'h00FF00FF00);
    check_all();

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule